// File: doc/BRIEF.md
# Pseudowire Receive Destination Dispatcher

The block sits after bundle lookup in the packet receive path. A packet arrives already tied to a bundle index, along with its 32-bit control word. The block decides where that packet goes. There are four possible destinations. The normal processing engine handles ordinary traffic. The CPU debug path receives whole packets when a bundle is set up for inspection. The CPU OAM path receives in-band connectivity-verification packets. The discard path drops the payload, which suits clock-only bundles.

Each bundle has its own small configuration entry, written through a synchronous register port addressed by bundle index. The entry holds a configured flag, a two-bit destination mode and two verification enables. Three global settings complete the decision: a control-word mask, a control-word value and an OAM discard switch. A packet counts as a verification packet when its control word matches the global value over the bits the mask selects. That check takes priority over the bundle's mode, but only when both of the bundle's enables are set. The result is a one-hot destination with a valid pulse, registered one cycle after the packet-start strobe.

Top module: `pwd_dispatch`

## Requirements
- R1: While reset is asserted and after it is released, `dst_valid` is 0. Every bundle entry starts unconfigured.
- R2: `dst_valid` is high in the cycle after a cycle in which `pkt_start` is high. It is low after every cycle in which `pkt_start` is low.
- R3: When `dst_valid` is high, exactly one bit of `dst_sel` is set. Bit 0 is the engine, bit 1 is CPU debug, bit 2 is CPU OAM and bit 3 is discard.
- R4: A packet whose bundle entry has its configured flag clear goes to discard. This holds whatever the control word and the global settings are.
- R5: For a configured bundle that takes no verification path, the mode field sets the destination. Mode 00 is the engine, 01 is CPU debug, 10 is discard and 11 is also discard.
- R6: A control word is a verification match when (cw AND mask) equals (value AND mask). Control-word bits where the mask is 0 do not affect the result.
- R7: The verification path applies only when both enables of the bundle are set. If only one is set, or neither, the packet follows its mode.
- R8: For a verification packet, `oam_discard` = 0 selects CPU OAM and `oam_discard` = 1 selects discard.
- R9: The verification path overrides every mode, including CPU debug and discard.
- R10: A configuration write takes effect for packets that start in later cycles. A packet that starts in the same cycle as a write to its bundle uses the entry as it was before the write.
- R11: A write changes only the entry at `cfg_addr`. Write data bit 4 is the configured flag, bits 3:2 are the mode, bit 1 is verification enable A and bit 0 is verification enable B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Bundle index to write |
| cfg_wdata | input | 5 | Entry data: {configured, mode[1:0], enable A, enable B} |
| cv_mask | input | 32 | Global control-word compare mask |
| cv_value | input | 32 | Global control-word compare value |
| oam_discard | input | 1 | 1: drop verification packets, 0: send them to the CPU |
| pkt_start | input | 1 | Packet-start strobe |
| pkt_bundle | input | 8 | Bundle index of the starting packet |
| pkt_cw | input | 32 | Control word of the starting packet |
| dst_valid | output | 1 | Decision valid pulse |
| dst_sel | output | 4 | One-hot destination |

## Verification
A configuration write and a packet start can land in the same cycle on the same bundle. The decision must then use the old entry, and the new one applies only from the next packet on. A directed case writes bundle 3 while a packet for it starts, then sends a second packet. The bench expects discard for the first packet and the engine for the second. The random phase draws bundle indices from a narrow range with frequent writes, so this collision recurs many times. Each packet is judged against a bench model updated only after the expected value for that cycle has been computed.

// File: rtl/pwd_pkg.sv
// Package: shared types and constants of the receive destination dispatcher.
// Assumes: the destination vector is one-hot in the bit order given below.
package pwd_pkg;

    typedef enum logic [1:0] {
        MODE_ENGINE = 2'b00,
        MODE_DEBUG  = 2'b01,
        MODE_DROP   = 2'b10,
        MODE_RSVD   = 2'b11
    } pwd_mode_e;

    typedef struct packed {
        logic      cfg_ok;
        pwd_mode_e mode;
        logic      cv_en_a;
        logic      cv_en_b;
    } pwd_entry_t;

    localparam int ENTRY_W = $bits(pwd_entry_t);
    localparam int DST_W   = 4;

    localparam logic [DST_W-1:0] DST_ENGINE = 4'b0001;
    localparam logic [DST_W-1:0] DST_DEBUG  = 4'b0010;
    localparam logic [DST_W-1:0] DST_OAM    = 4'b0100;
    localparam logic [DST_W-1:0] DST_DROP   = 4'b1000;

endpackage

// File: rtl/pwd_cfg_table.sv
// Module: per-bundle configuration store.
// It has one synchronous write port and one combinational read port.
// A read in the same cycle as a write returns the old contents.
// Assumes: the index width covers N_BUNDLE entries. Reset clears only the configured flags.
module pwd_cfg_table
    import pwd_pkg::*;
#(
    parameter int N_BUNDLE = 256,
    parameter int IDX_W    = $clog2(N_BUNDLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pwd_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output pwd_entry_t       rd_entry
);

    pwd_entry_t tbl [N_BUNDLE];

    // Purpose: clear the configured flags on reset, otherwise store a written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BUNDLE; i++) begin
                tbl[i].cfg_ok <= 1'b0;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    // Purpose: look up the entry of the starting packet.
    always_comb begin
        rd_entry = tbl[rd_idx];
    end

    // R11: a write lands in the addressed entry
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl[$past(wr_idx)] == $past(wr_entry));

endmodule

// File: rtl/pwd_cw_match.sv
// Module: masked compare of a control word against a global value.
// Assumes: the mask selects the bits to compare; the other bits are ignored.
module pwd_cw_match #(
    parameter int CW_W = 32
) (
    input  logic [CW_W-1:0] cw,
    input  logic [CW_W-1:0] mask,
    input  logic [CW_W-1:0] value,
    output logic            hit
);

    logic [CW_W-1:0] diff;

    // Purpose: flag any selected bit that differs.
    always_comb begin
        diff = (cw ^ value) & mask;
        hit  = (diff == '0);
    end

endmodule

// File: rtl/pwd_route_sel.sv
// Module: destination priority and output register.
// Priority order: unconfigured entry, then verification path, then bundle mode.
// Assumes: entry and hit are valid in the cycle pkt_start is high.
module pwd_route_sel
    import pwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  pwd_entry_t       entry,
    input  logic             cv_hit,
    input  logic             oam_discard,
    output logic             dst_valid,
    output logic [DST_W-1:0] dst_sel
);

    logic             cv_path;
    logic [DST_W-1:0] mode_dst;
    logic [DST_W-1:0] nxt_dst;

    // Purpose: map the bundle mode to a destination.
    always_comb begin
        unique case (entry.mode)
            MODE_ENGINE: mode_dst = DST_ENGINE;
            MODE_DEBUG:  mode_dst = DST_DEBUG;
            MODE_DROP:   mode_dst = DST_DROP;
            default:     mode_dst = DST_DROP;
        endcase
    end

    // Purpose: apply the priority order to pick one destination.
    always_comb begin
        cv_path = entry.cv_en_a && entry.cv_en_b && cv_hit;
        if (!entry.cfg_ok) begin
            nxt_dst = DST_DROP;
        end else if (cv_path) begin
            nxt_dst = oam_discard ? DST_DROP : DST_OAM;
        end else begin
            nxt_dst = mode_dst;
        end
    end

    // Purpose: register the decision and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_valid <= 1'b0;
            dst_sel   <= '0;
        end else begin
            dst_valid <= start;
            dst_sel   <= start ? nxt_dst : '0;
        end
    end

    // R2: a decision follows each start
    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> dst_valid);
    // R2: no decision without a start
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !dst_valid);
    // R3: exactly one destination
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> $countones(dst_sel) == 1);
    // R4: unconfigured bundles go to discard
    a_r4_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !entry.cfg_ok) |=> dst_sel == DST_DROP);
    // R8: OAM drop switch discards verification packets
    a_r8_oam_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (start && entry.cfg_ok && entry.cv_en_a && entry.cv_en_b && cv_hit && oam_discard)
        |=> dst_sel == DST_DROP);
    // R9: verification path overrides the mode
    a_r9_cv_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (start && entry.cfg_ok && entry.cv_en_a && entry.cv_en_b && cv_hit && !oam_discard)
        |=> dst_sel == DST_OAM);
    // R7: a single enable leaves engine-mode packets on the engine
    a_r7_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (start && entry.cfg_ok && !(entry.cv_en_a && entry.cv_en_b) && entry.mode == MODE_ENGINE)
        |=> dst_sel == DST_ENGINE);

endmodule

// File: rtl/pwd_dispatch.sv
// Module: top of the pseudowire receive destination dispatcher.
// It looks up the bundle entry, runs the masked control-word compare and
// registers a one-hot destination one cycle after pkt_start.
// Assumes: global mask, value and discard switch are steady during a start cycle.
module pwd_dispatch
    import pwd_pkg::*;
#(
    parameter int N_BUNDLE = 256,
    parameter int IDX_W    = $clog2(N_BUNDLE),
    parameter int CW_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [4:0]       cfg_wdata,
    input  logic [CW_W-1:0]  cv_mask,
    input  logic [CW_W-1:0]  cv_value,
    input  logic             oam_discard,
    input  logic             pkt_start,
    input  logic [IDX_W-1:0] pkt_bundle,
    input  logic [CW_W-1:0]  pkt_cw,
    output logic             dst_valid,
    output logic [3:0]       dst_sel
);

    pwd_entry_t wr_entry;
    pwd_entry_t rd_entry;
    logic       cv_hit;

    // Purpose: view the raw write data as an entry.
    always_comb begin
        wr_entry = pwd_entry_t'(cfg_wdata);
    end

    pwd_cfg_table #(
        .N_BUNDLE (N_BUNDLE),
        .IDX_W    (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_addr),
        .wr_entry (wr_entry),
        .rd_idx   (pkt_bundle),
        .rd_entry (rd_entry)
    );

    pwd_cw_match #(
        .CW_W  (CW_W)
    ) u_match (
        .cw    (pkt_cw),
        .mask  (cv_mask),
        .value (cv_value),
        .hit   (cv_hit)
    );

    pwd_route_sel u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (pkt_start),
        .entry       (rd_entry),
        .cv_hit      (cv_hit),
        .oam_discard (oam_discard),
        .dst_valid   (dst_valid),
        .dst_sel     (dst_sel)
    );

    // R1: no decision in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !dst_valid);

endmodule

// File: tb/pwd_dispatch_tb_top.sv
// Bench: directed corner cases and seeded random traffic against a bench model.
module pwd_dispatch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [4:0]  cfg_wdata;
    logic [31:0] cv_mask;
    logic [31:0] cv_value;
    logic        oam_discard;
    logic        pkt_start;
    logic [7:0]  pkt_bundle;
    logic [31:0] pkt_cw;
    logic        dst_valid;
    logic [3:0]  dst_sel;

    int total = 0;
    int bad   = 0;
    logic [4:0] model [256];

    always #10 clk = ~clk;

    pwd_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cv_mask(cv_mask), .cv_value(cv_value),
        .oam_discard(oam_discard), .pkt_start(pkt_start), .pkt_bundle(pkt_bundle),
        .pkt_cw(pkt_cw), .dst_valid(dst_valid), .dst_sel(dst_sel)
    );

    // Expected destination from the requirement rules (R4..R9).
    function automatic logic [3:0] exp_dest(logic [4:0] e, logic [31:0] cw,
                                            logic [31:0] m, logic [31:0] v, logic od);
        if (!e[4]) return 4'b1000;
        if (e[1] && e[0] && (((cw & m) == (v & m)))) return od ? 4'b1000 : 4'b0100;
        case (e[3:2])
            2'b00:   return 4'b0001;
            2'b01:   return 4'b0010;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle, entered and left at a negedge.
    // Checks the valid pulse and, after a start, the destination.
    task automatic step(string req, logic s, logic [7:0] b, logic [31:0] cw,
                        logic we, logic [7:0] wa, logic [4:0] wd);
        logic [3:0] e;
        e = exp_dest(model[b], cw, cv_mask, cv_value, oam_discard);
        pkt_start = s; pkt_bundle = b; pkt_cw = cw;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        @(posedge clk);
        if (we) model[wa] = wd;
        @(negedge clk);
        pkt_start = 1'b0; cfg_we = 1'b0;
        check({req, " valid"}, {3'b0, dst_valid}, {3'b0, s});
        if (s) check(req, dst_sel, e);
    endtask

    task automatic wr(logic [7:0] a, logic [4:0] d);
        step("R11 write", 1'b0, 8'd0, 32'd0, 1'b1, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] cw;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) model[i] = 5'd0;
        rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        cv_mask = 32'hFFFF_0000; cv_value = 32'hABCD_1234; oam_discard = 0;
        pkt_start = 0; pkt_bundle = 0; pkt_cw = 0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {3'b0, dst_valid}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {3'b0, dst_valid}, 4'b0);

        // R4: unconfigured bundle with a matching control word
        step("R4 unconfigured", 1, 8'd7, 32'hABCD_0000, 0, 0, 0);
        // R10: write and start on the same bundle in one cycle
        step("R10 same-cycle old entry", 1, 8'd3, 32'h0, 1, 8'd3, 5'b1_00_00);
        step("R10 next packet new entry", 1, 8'd3, 32'h0, 0, 0, 0);
        // R5: modes
        wr(8'd4, 5'b1_01_00); wr(8'd5, 5'b1_10_00); wr(8'd6, 5'b1_11_00);
        step("R5 mode debug", 1, 8'd4, 32'h0, 0, 0, 0);
        step("R5 mode discard", 1, 8'd5, 32'h0, 0, 0, 0);
        step("R5 mode reserved", 1, 8'd6, 32'h0, 0, 0, 0);
        // R6: masked compare
        wr(8'd8, 5'b1_00_11);
        step("R6 match ignoring unmasked bits", 1, 8'd8, 32'hABCD_9999, 0, 0, 0);
        step("R6 mismatch in masked bit", 1, 8'd8, 32'hABCE_1234, 0, 0, 0);
        // R7: single enable
        wr(8'd9, 5'b1_00_10); wr(8'd10, 5'b1_00_01);
        step("R7 enable A only", 1, 8'd9, 32'hABCD_0000, 0, 0, 0);
        step("R7 enable B only", 1, 8'd10, 32'hABCD_0000, 0, 0, 0);
        // R9: verification path overrides debug and discard modes
        wr(8'd11, 5'b1_01_11); wr(8'd12, 5'b1_10_11);
        step("R9 over debug", 1, 8'd11, 32'hABCD_0001, 0, 0, 0);
        step("R9 over discard", 1, 8'd12, 32'hABCD_0002, 0, 0, 0);
        // R8: OAM discard switch
        oam_discard = 1'b1;
        step("R8 oam dropped", 1, 8'd8, 32'hABCD_0003, 0, 0, 0);
        oam_discard = 1'b0;
        // R11: write touches only its address
        wr(8'd13, 5'b1_01_00);
        step("R11 neighbour untouched", 1, 8'd14, 32'h0, 0, 0, 0);
        step("R11 written entry", 1, 8'd13, 32'h0, 0, 0, 0);
        // R2: idle cycle
        step("R2 idle", 0, 8'd13, 32'h0, 0, 0, 0);

        // Random traffic: R2 R3 and the rules above
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 50) == 0) begin
                cv_mask = $urandom; cv_value = $urandom;
            end
            if (($urandom % 20) == 0) oam_discard = ~oam_discard;
            cw = (($urandom % 2) == 0) ? (cv_value ^ ($urandom & ~cv_mask)) : $urandom;
            step("R3 random", ($urandom % 4) != 0, 8'($urandom % 16), cw,
                 ($urandom % 3) == 0, 8'($urandom % 16), 5'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule